// File: doc/BRIEF.md
# Accumulator Arithmetic-Logic Unit with Nibble Carry

This block is the arithmetic core of a small microcontroller datapath. It holds a working register (an accumulator that has no address on any data bus) and three condition flags: carry, digit carry and zero. For each operation, one operand is always the working register. The other operand is picked from three sources: a file-register data input, a literal input, or the working register itself. The unit can add, subtract, rotate through carry, apply bitwise logic, complement, move or clear. Which flags an operation changes depends on the operation.

Results are available combinationally on `result_o` in the same cycle. A destination select decides where the result goes. It can be loaded into the working register at the next rising clock edge. It can instead be offered to an external register file: `file_we_o` is raised and the working register stays unchanged. Flags update on the same edge. Instruction decode, the register file and banking lie outside this block.

Top module: `alu8_wreg_core`

## Requirements
- R1: While `rst_n` is low, the working register reads 0x00 and carry, digit carry and zero all read 0.
- R2: Operation code 1 (add) yields (B + W) mod 256. Carry is set to the carry out of bit 7. Digit carry is set to the carry out of bit 3.
- R3: Operation code 2 (subtract) yields (B − W) mod 256, where B is the selected operand and W the working register. Carry is set exactly when B ≥ W (no borrow). Digit carry is set exactly when B[3:0] ≥ W[3:0] (no nibble borrow).
- R4: The following operations update zero and set it exactly when the result is 0x00: move (0), add (1), subtract (2), AND (3), OR (4), XOR (5), complement (6) and clear (9).
- R5: AND (3), OR (4), XOR (5) and complement (6, result ~B) change neither carry nor digit carry.
- R6: Rotate-left (7) yields {B[6:0], C} and loads C with B[7]. Rotate-right (8) yields {C, B[7:1]} and loads C with B[0]. Both rotates leave zero and digit carry unchanged.
- R7: Source select 0 picks `file_i` as operand B. Source select 1 picks `lit_i`. Source selects 2 and 3 pick the working register.
- R8: With `dest_i` = 0, the result loads the working register at the next rising edge and `file_we_o` is low. With `dest_i` = 1, `file_we_o` is high in that cycle and the working register keeps its value.
- R9: Operation codes 10 to 15 are no-operations. Working register and flags hold, and `file_we_o` stays low.
- R10: Move (0) yields B unchanged. Clear (9) yields 0x00. Neither touches carry or digit carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code |
| src_i | input | 2 | Operand B source select |
| file_i | input | 8 | File-register data operand |
| lit_i | input | 8 | Literal operand |
| dest_i | input | 1 | 0 = working register, 1 = file register |
| result_o | output | 8 | Combinational operation result |
| file_we_o | output | 1 | Result is destined for the file register |
| w_o | output | 8 | Working register contents |
| c_o | output | 1 | Carry / no-borrow flag |
| dc_o | output | 1 | Digit carry / no nibble-borrow flag |
| z_o | output | 1 | Zero flag |

## Verification
Some properties are checked on every cycle by the assertions:
- the adder's sum and both carries agree with plain integer addition;
- rotation neither creates nor loses set bits across carry and data;
- logic operations and no-operations leave the held state stable;
- a file-destined result never disturbs the working register;
- subtracting equal values gives zero with both no-borrow flags set.

The exact result and flag values are a different matter. The bench shows them by sweeping add and subtract over every operand against a broad spread of working-register values. It also sweeps the rotates over every operand with both carry values, and exercises each source select and each destination.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

   typedef enum logic [3:0] {
      OP_MOV = 4'd0,
      OP_ADD = 4'd1,
      OP_SUB = 4'd2,
      OP_AND = 4'd3,
      OP_OR  = 4'd4,
      OP_XOR = 4'd5,
      OP_COM = 4'd6,
      OP_RLC = 4'd7,
      OP_RRC = 4'd8,
      OP_CLR = 4'd9
   } op_e;

   typedef enum logic [1:0] {
      LG_AND = 2'd0,
      LG_OR  = 2'd1,
      LG_XOR = 2'd2,
      LG_NOT = 2'd3
   } logic_sel_e;

   localparam logic [1:0] SRC_FILE = 2'd0;
   localparam logic [1:0] SRC_LIT  = 2'd1;

   function automatic logic op_is_valid(input logic [3:0] code);
      return code <= 4'd9;
   endfunction

   function automatic logic op_is_logic(input logic [3:0] code);
      return (code >= 4'd3) && (code <= 4'd6);
   endfunction

endpackage

// File: rtl/alu8_adder.sv
module alu8_adder #(
   parameter int WIDTH  = 8,
   parameter int DIGIT  = 4,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             ci_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             co_o,
   output logic             dco_o
);
   localparam int HI = WIDTH - DIGIT;

   if (DIGIT < 1 || DIGIT >= WIDTH) begin : g_bad_digit
      $error("alu8_adder: DIGIT must lie in 1..WIDTH-1");
   end

   if (RIPPLE) begin : g_ripple
      logic [WIDTH:0] cy;
      assign cy[0] = ci_i;
      for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
         assign sum_o[gi]  = a_i[gi] ^ b_i[gi] ^ cy[gi];
         assign cy[gi + 1] = (a_i[gi] & b_i[gi]) | (cy[gi] & (a_i[gi] ^ b_i[gi]));
      end
      assign co_o  = cy[WIDTH];
      assign dco_o = cy[DIGIT];
   end else begin : g_split
      logic [DIGIT:0] lo;
      logic [HI:0]    hi;
      assign lo    = {1'b0, a_i[DIGIT-1:0]} + {1'b0, b_i[DIGIT-1:0]}
                     + {{DIGIT{1'b0}}, ci_i};
      assign hi    = {1'b0, a_i[WIDTH-1:DIGIT]} + {1'b0, b_i[WIDTH-1:DIGIT]}
                     + {{HI{1'b0}}, lo[DIGIT]};
      assign sum_o = {hi[HI-1:0], lo[DIGIT-1:0]};
      assign co_o  = hi[HI];
      assign dco_o = lo[DIGIT];
   end

   logic [WIDTH:0] ref_full;
   logic [DIGIT:0] ref_low;
   always_comb begin
      ref_full = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, ci_i};
      ref_low  = {1'b0, a_i[DIGIT-1:0]} + {1'b0, b_i[DIGIT-1:0]}
                 + {{DIGIT{1'b0}}, ci_i};
      // R2
      add_sum_chk: assert ({co_o, sum_o} == ref_full)
         else $error("adder sum/carry disagrees with integer sum");
      // R3
      digit_carry_chk: assert (dco_o == ref_low[DIGIT])
         else $error("adder digit carry disagrees with nibble sum");
   end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
   import alu8_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic_sel_e       sel_i,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] res_o
);
   if (WIDTH < 2) begin : g_bad_width
      $error("alu8_logic: WIDTH must be at least 2");
   end

   always_comb begin
      unique case (sel_i)
         LG_AND:  res_o = a_i & b_i;
         LG_OR:   res_o = a_i | b_i;
         LG_XOR:  res_o = a_i ^ b_i;
         default: res_o = ~a_i;
      endcase
   end

endmodule

// File: rtl/alu8_rotate.sv
module alu8_rotate #(
   parameter int WIDTH = 8
) (
   input  logic             right_i,
   input  logic [WIDTH-1:0] d_i,
   input  logic             cin_i,
   output logic [WIDTH-1:0] res_o,
   output logic             cout_o
);
   localparam int MSB = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("alu8_rotate: WIDTH must be at least 2");
   end

   always_comb begin
      if (right_i) begin
         res_o  = {cin_i, d_i[MSB:1]};
         cout_o = d_i[0];
      end else begin
         res_o  = {d_i[MSB-1:0], cin_i};
         cout_o = d_i[MSB];
      end
   end

   always_comb begin
      // R6
      rotate_bits_chk: assert ($countones({cin_i, d_i}) == $countones({cout_o, res_o}))
         else $error("rotate through carry lost or created a bit");
   end

endmodule

// File: rtl/alu8_wreg_core.sv
module alu8_wreg_core
   import alu8_pkg::*;
#(
   parameter int WIDTH  = 8,
   parameter int DIGIT  = 4,
   parameter bit RIPPLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [3:0]       op_i,
   input  logic [1:0]       src_i,
   input  logic [WIDTH-1:0] file_i,
   input  logic [WIDTH-1:0] lit_i,
   input  logic             dest_i,
   output logic [WIDTH-1:0] result_o,
   output logic             file_we_o,
   output logic [WIDTH-1:0] w_o,
   output logic             c_o,
   output logic             dc_o,
   output logic             z_o
);
   if (WIDTH < 2 || DIGIT < 1 || DIGIT >= WIDTH) begin : g_bad_cfg
      $error("alu8_wreg_core: need WIDTH >= 2 and 1 <= DIGIT < WIDTH");
   end

   logic [WIDTH-1:0] w_q;
   logic             c_q, dc_q, z_q;
   logic [WIDTH-1:0] opnd;
   op_e              op;
   logic             valid;

   assign op    = op_e'(op_i);
   assign valid = op_is_valid(op_i);

   always_comb begin
      case (src_i)
         SRC_FILE: opnd = file_i;
         SRC_LIT:  opnd = lit_i;
         default:  opnd = w_q;
      endcase
   end

   // arithmetic: subtraction adds the two's complement of W
   logic             is_sub;
   logic [WIDTH-1:0] add_b, add_sum;
   logic             add_co, add_dco;
   assign is_sub = (op == OP_SUB);
   assign add_b  = is_sub ? ~w_q : w_q;

   alu8_adder #(.WIDTH(WIDTH), .DIGIT(DIGIT), .RIPPLE(RIPPLE)) u_add (
      .a_i(opnd), .b_i(add_b), .ci_i(is_sub),
      .sum_o(add_sum), .co_o(add_co), .dco_o(add_dco)
   );

   logic_sel_e       lsel;
   logic [WIDTH-1:0] lg_res;
   always_comb begin
      case (op)
         OP_AND:  lsel = LG_AND;
         OP_OR:   lsel = LG_OR;
         OP_XOR:  lsel = LG_XOR;
         default: lsel = LG_NOT;
      endcase
   end

   alu8_logic #(.WIDTH(WIDTH)) u_logic (
      .sel_i(lsel), .a_i(opnd), .b_i(w_q), .res_o(lg_res)
   );

   logic [WIDTH-1:0] rot_res;
   logic             rot_c;
   alu8_rotate #(.WIDTH(WIDTH)) u_rot (
      .right_i(op == OP_RRC), .d_i(opnd), .cin_i(c_q),
      .res_o(rot_res), .cout_o(rot_c)
   );

   logic upd_c, upd_dc, upd_z;
   logic nxt_c, nxt_dc;
   always_comb begin
      result_o = '0;
      upd_c    = 1'b0;
      upd_dc   = 1'b0;
      upd_z    = 1'b0;
      nxt_c    = add_co;
      nxt_dc   = add_dco;
      case (op)
         OP_MOV: begin result_o = opnd; upd_z = 1'b1; end
         OP_ADD, OP_SUB: begin
            result_o = add_sum; upd_c = 1'b1; upd_dc = 1'b1; upd_z = 1'b1;
         end
         OP_AND, OP_OR, OP_XOR, OP_COM: begin result_o = lg_res; upd_z = 1'b1; end
         OP_RLC, OP_RRC: begin result_o = rot_res; upd_c = 1'b1; nxt_c = rot_c; end
         OP_CLR: begin result_o = '0; upd_z = 1'b1; end
         default: result_o = '0;
      endcase
   end

   assign file_we_o = valid & dest_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         w_q  <= '0;
         c_q  <= 1'b0;
         dc_q <= 1'b0;
         z_q  <= 1'b0;
      end else begin
         if (valid && !dest_i) w_q <= result_o;
         if (upd_c)  c_q  <= nxt_c;
         if (upd_dc) dc_q <= nxt_dc;
         if (upd_z)  z_q  <= (result_o == '0);
      end
   end

   assign w_o  = w_q;
   assign c_o  = c_q;
   assign dc_o = dc_q;
   assign z_o  = z_q;

   // R5
   logic_keeps_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_is_logic(op_i) |=> ($stable(c_o) && $stable(dc_o)));

   // R9
   nop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !op_is_valid(op_i) |=> ($stable(w_o) && $stable({c_o, dc_o, z_o})));

   // R8
   dest_file_keeps_w_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dest_i |=> $stable(w_o));

   // R6
   rotate_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 4'd7) |=> (c_o == $past(opnd[WIDTH-1])));

   // R3
   sub_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 4'd2 && opnd == w_o) |=> (z_o && c_o && dc_o));

endmodule

// File: tb/alu8_wreg_core_tb.sv
module alu8_wreg_core_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] op_i = 4'd15;
   logic [1:0] src_i = 2'd0;
   logic [7:0] file_i = '0, lit_i = '0;
   logic       dest_i = 1'b0;
   logic [7:0] result_o, w_o;
   logic       file_we_o, c_o, dc_o, z_o;

   int n_chk = 0;
   int n_bad = 0;

   logic [7:0] m_w;
   logic       m_c, m_dc, m_z;

   always #10 clk = ~clk;

   alu8_wreg_core dut_i (
      .clk(clk), .rst_n(rst_n), .op_i(op_i), .src_i(src_i),
      .file_i(file_i), .lit_i(lit_i), .dest_i(dest_i),
      .result_o(result_o), .file_we_o(file_we_o), .w_o(w_o),
      .c_o(c_o), .dc_o(dc_o), .z_o(z_o)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic do_op(input string req, input int op, input int src,
                        input int f, input int l, input int dst);
      int b, r, nc, ndc, nz;
      b = (src == 0) ? f : (src == 1) ? l : int'(m_w);
      r = 0; nc = m_c; ndc = m_dc; nz = m_z;
      case (op)
         0: begin r = b; nz = (r == 0); end
         1: begin r = (b + m_w) % 256; nc = (b + m_w) > 255;
                  ndc = ((b % 16) + (m_w % 16)) > 15; nz = (r == 0); end
         2: begin r = (b - m_w + 256) % 256; nc = (b >= m_w);
                  ndc = ((b % 16) >= (m_w % 16)); nz = (r == 0); end
         3: begin r = b & m_w; nz = (r == 0); end
         4: begin r = b | m_w; nz = (r == 0); end
         5: begin r = b ^ m_w; nz = (r == 0); end
         6: begin r = 255 - b; nz = (r == 0); end
         7: begin r = ((b * 2) % 256) + m_c; nc = b / 128; end
         8: begin r = (b / 2) + 128 * m_c; nc = b % 2; end
         9: begin r = 0; nz = 1; end
         default: r = 0;
      endcase
      @(negedge clk);
      op_i = op[3:0]; src_i = src[1:0]; file_i = f[7:0]; lit_i = l[7:0]; dest_i = dst[0];
      #5;
      if (op <= 9) check(req, "result", result_o, r);
      check(req, "file_we", file_we_o, (op <= 9) && dst == 1);
      @(negedge clk);
      if (op <= 9) begin
         if (dst == 0) m_w = r[7:0];
         m_c = nc[0]; m_dc = ndc[0]; m_z = nz[0];
      end
      check(req, "w", w_o, m_w);
      check(req, "c", c_o, m_c);
      check(req, "dc", dc_o, m_dc);
      check(req, "z", z_o, m_z);
      op_i = 4'd15;
   endtask

   initial begin
      #(20 * 190000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      m_w = 0; m_c = 0; m_dc = 0; m_z = 0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", "w", w_o, 0);
      check("R1", "flags", {c_o, dc_o, z_o}, 0);
      rst_n = 1'b1;

      // R2 / R3 / R4: add and subtract sweep, file destination keeps W (R8)
      for (int wv = 0; wv < 256; wv += 3) begin
         do_op("R10", 0, 1, 0, wv, 0);
         for (int b = 0; b < 256; b++) begin
            do_op("R2", 1, 0, b, 0, 1);
            do_op("R3", 2, 1, 0, b, 1);
         end
      end
      // R3 boundary: W minus itself via source select 2 and 3 (R7)
      do_op("R10", 0, 1, 0, 8'h5a, 0);
      do_op("R3", 2, 2, 0, 0, 1);
      do_op("R7", 2, 3, 0, 0, 0);

      // R5 logic and complement, W spread
      for (int wv = 0; wv < 256; wv += 37) begin
         do_op("R10", 0, 0, wv, 0, 0);
         for (int b = 0; b < 256; b++) begin
            do_op("R5", 3, 0, b, 0, 1);
            do_op("R5", 4, 1, 0, b, 1);
            do_op("R5", 5, 0, b, 0, 1);
            do_op("R5", 6, 1, 0, b, 1);
         end
      end

      // R6 rotates over every operand with both carry values
      do_op("R10", 0, 1, 0, 8'h80, 0);
      for (int b = 0; b < 256; b++) begin
         for (int cc = 0; cc < 2; cc++) begin
            do_op("R2", 1, 1, 0, cc * 128, 1);
            do_op("R6", 7, 0, b, 0, 1);
            do_op("R2", 1, 1, 0, cc * 128, 1);
            do_op("R6", 8, 1, 0, b, 1);
         end
      end
      // R6 rotate chain on W itself into W
      do_op("R10", 0, 1, 0, 8'hc3, 0);
      for (int k = 0; k < 10; k++) do_op("R6", 7, 2, 0, 0, 0);
      for (int k = 0; k < 10; k++) do_op("R6", 8, 2, 0, 0, 0);

      // R8 add into W
      do_op("R8", 1, 1, 0, 8'h17, 0);
      do_op("R8", 1, 0, 8'hf0, 0, 0);
      // R10 clear and move
      do_op("R10", 9, 0, 0, 0, 0);
      do_op("R10", 0, 0, 8'h00, 0, 1);
      do_op("R10", 0, 1, 0, 8'h3c, 0);
      // R9 no-operation codes with both destinations
      for (int op = 10; op < 16; op++) begin
         do_op("R9", op, 1, 8'hff, 8'h00, 0);
         do_op("R9", op, 0, 8'hff, 8'h00, 1);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule